// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the free-running clock sources of a system clock generator and its output pins. It takes a free-running CPU clock, a PCI-rate clock and a reference clock. It drives a group of CPU outputs, a group of gated PCI outputs, one PCI output that is never stopped by the PCI stop control, and one reference output. Three active-low controls act on the outputs: a CPU-group stop, a PCI-group stop and a whole-block power-down.

Each gate captures its enable on the falling edge of its own source clock and ANDs it with that clock. An output therefore only starts or stops at a full-cycle boundary and never produces a shortened or stretched pulse. The stop inputs pass through a two-stage synchronizer clocked by the free-running PCI clock. After the CPU stop is released, a counter in the CPU domain holds the CPU group off for a minimum number of CPU periods. Power-down acts asynchronously and takes priority over both stops. When it is released, a reference-cycle counter models the settling time of the oscillator and PLL before any output runs again. A reset behaves like a power-down.

The timing below assumes two synchronizer stages and a CPU clock whose rising edges coincide with PCI rising edges at an integer ratio.

Top module: `clockStopUnit`

## Requirements
- R1: While `rstN` is low every output is held at 0, and it stays at 0 until the power-up settling interval (R10) has elapsed.
- R2: Once `cpuStopN` falls, the last CPU pulse begins at the second `pciClk` rising edge after the change. After that, every `cpuOut` bit stays at 0 for as long as `cpuStopN` stays low.
- R3: Once `pciStopN` falls, the last pulse on the gated PCI outputs begins at the second `pciClk` rising edge after the change. After that, every `pciOut` bit stays at 0 for as long as `pciStopN` stays low.
- R4: `pciStopN` has no effect on `pciFreeOut`, `refOut` or `cpuOut`. `cpuStopN` has no effect on `pciOut`, `pciFreeOut` or `refOut`. Over any window the unaffected outputs produce exactly as many pulses as their sources.
- R5: After `pciStopN` rises, the first gated PCI pulse begins at the third `pciClk` rising edge after the change.
- R6: After `cpuStopN` rises, the first CPU pulse begins RESTART_CYCLES+1 CPU periods after the second `pciClk` rising edge. It is never sooner than RESTART_CYCLES CPU periods after the CPU group is re-enabled.
- R7: `pdN` low is acted on asynchronously. `cpuOut`, `pciOut` and `pciFreeOut` finish the pulse in progress and are low from the second `pciClk` rising edge onward.
- R8: During power-down `refOut` stops at its own next falling edge, independent of the PCI-edge counting, and stays at 0.
- R9: While `pdN` is low, changes on `cpuStopN` and `pciStopN` leave every output at 0.
- R10: After `pdN` (or `rstN`) rises, no output rises sooner than SETTLE_CYCLES reference periods later. `refOut` rises within SETTLE_CYCLES+6 reference periods.
- R11: Each output high pulse lasts exactly its source's high time. Each output low gap is at least its source's low time. No output is ever high while its source is low.
- R12: With all controls inactive and power settled, every output follows its source, and `pciFreeOut` is high whenever any gated PCI output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | Free-running CPU clock |
| pciClk | input | 1 | Free-running PCI clock; clocks the control synchronizers |
| refClk | input | 1 | Free-running reference clock; clocks the settle counter |
| rstN | input | 1 | Asynchronous active-low reset |
| pdN | input | 1 | Asynchronous active-low power-down |
| cpuStopN | input | 1 | Active-low stop for the CPU group |
| pciStopN | input | 1 | Active-low stop for the gated PCI group |
| cpuOut | output | CPU_OUTS | Gated CPU clocks |
| pciOut | output | PCI_OUTS | Gated PCI clocks |
| pciFreeOut | output | 1 | PCI clock stopped only by power-down |
| refOut | output | 1 | Reference clock stopped only by power-down |

## Verification
The bench uses SETTLE_CYCLES = 16 so that the settle interval can be crossed twice, after reset and after power-down, within a short run. RESTART_CYCLES keeps its default of 3. The CPU, PCI and reference clocks run at a 3:1 CPU-to-PCI ratio with the reference unrelated in phase. This exposes the exact restart edge, the count of pulses that get through after each stop, and the pulse widths of all three clock families.

// File: rtl/clockStopPkg.sv
package clockStopPkg;

  // Per-group run strobes handed from control to the gating datapath.
  typedef struct packed {
    logic refRun;   // reference domain
    logic freeRun;  // PCI domain, free PCI output
    logic pciRun;   // PCI domain, gated PCI group
    logic cpuRun;   // PCI domain, CPU group before restart hold-off
  } gateStrobes_t;

endpackage

// File: rtl/clockStopSync.sv
module clockStopSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/clockStopGate.sv
module clockStopGate (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  output logic gclk
);

  logic enLow;

  // The enable is captured only while the clock is low, so the AND can
  // never clip or extend a high phase.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) enLow <= 1'b0;
    else       enLow <= en;
  end

  assign gclk = clk & enLow;

endmodule

// File: rtl/clockStopCtrl.sv
module clockStopCtrl
  import clockStopPkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 43000
) (
  input  logic         pciClk,
  input  logic         refClk,
  input  logic         rstN,
  input  logic         pdN,
  input  logic         cpuStopN,
  input  logic         pciStopN,
  output gateStrobes_t strobes
);

  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

  logic powerOnN;
  logic refPowered;
  logic refGood;
  logic pciGood;
  logic cpuGoSync;
  logic pciGoSync;
  logic [SETTLE_W-1:0] settleCnt;

  // Power-down and reset clear every power-related stage at once.
  assign powerOnN = rstN & pdN;

  clockStopSync #(.STAGES(SYNC_STAGES)) refPowerSync (
    .clk(refClk), .arstN(powerOnN), .d(1'b1), .q(refPowered)
  );

  // Settling model: count reference cycles once the release is synchronized.
  always_ff @(posedge refClk or negedge powerOnN) begin
    if (!powerOnN) begin
      settleCnt <= '0;
      refGood   <= 1'b0;
    end else if (refPowered && !refGood) begin
      if (settleCnt == SETTLE_W'(SETTLE_CYCLES - 1)) refGood <= 1'b1;
      else                                           settleCnt <= settleCnt + 1'b1;
    end
  end

  clockStopSync #(.STAGES(SYNC_STAGES)) pciPowerSync (
    .clk(pciClk), .arstN(powerOnN), .d(refGood), .q(pciGood)
  );

  clockStopSync #(.STAGES(SYNC_STAGES)) cpuStopSync (
    .clk(pciClk), .arstN(rstN), .d(cpuStopN), .q(cpuGoSync)
  );

  clockStopSync #(.STAGES(SYNC_STAGES)) pciStopSync (
    .clk(pciClk), .arstN(rstN), .d(pciStopN), .q(pciGoSync)
  );

  // Power state dominates both stop requests.
  always_comb begin
    strobes.refRun  = refGood;
    strobes.freeRun = pciGood;
    strobes.pciRun  = pciGood & pciGoSync;
    strobes.cpuRun  = pciGood & cpuGoSync;
  end

endmodule

// File: rtl/clockStopPath.sv
module clockStopPath
  import clockStopPkg::*;
#(
  parameter int CPU_OUTS       = 2,
  parameter int PCI_OUTS       = 5,
  parameter int RESTART_CYCLES = 3
) (
  input  logic                cpuClk,
  input  logic                pciClk,
  input  logic                refClk,
  input  logic                rstN,
  input  gateStrobes_t        strobes,
  output logic [CPU_OUTS-1:0] cpuOut,
  output logic [PCI_OUTS-1:0] pciOut,
  output logic                pciFreeOut,
  output logic                refOut
);

  localparam int RESTART_W = $clog2(RESTART_CYCLES + 1);

  logic [RESTART_W-1:0] restartCnt;
  logic cpuHoldDone;
  logic cpuEnable;

  // Restart hold-off, counted in CPU periods; a stop clears it immediately.
  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      restartCnt  <= '0;
      cpuHoldDone <= 1'b0;
    end else if (!strobes.cpuRun) begin
      restartCnt  <= '0;
      cpuHoldDone <= 1'b0;
    end else if (!cpuHoldDone) begin
      if (restartCnt == RESTART_W'(RESTART_CYCLES - 1)) cpuHoldDone <= 1'b1;
      else                                              restartCnt  <= restartCnt + 1'b1;
    end
  end

  assign cpuEnable = strobes.cpuRun & cpuHoldDone;

  for (genvar i = 0; i < CPU_OUTS; i++) begin : genCpuGate
    clockStopGate cpuGate (
      .clk(cpuClk), .rstN(rstN), .en(cpuEnable), .gclk(cpuOut[i])
    );
  end

  for (genvar j = 0; j < PCI_OUTS; j++) begin : genPciGate
    clockStopGate pciGate (
      .clk(pciClk), .rstN(rstN), .en(strobes.pciRun), .gclk(pciOut[j])
    );
  end

  clockStopGate freeGate (
    .clk(pciClk), .rstN(rstN), .en(strobes.freeRun), .gclk(pciFreeOut)
  );

  clockStopGate refGate (
    .clk(refClk), .rstN(rstN), .en(strobes.refRun), .gclk(refOut)
  );

endmodule

// File: rtl/clockStopUnit.sv
module clockStopUnit
  import clockStopPkg::*;
#(
  parameter int CPU_OUTS       = 2,
  parameter int PCI_OUTS       = 5,
  parameter int SYNC_STAGES    = 2,
  parameter int RESTART_CYCLES = 3,
  parameter int SETTLE_CYCLES  = 43000
) (
  input  logic                cpuClk,
  input  logic                pciClk,
  input  logic                refClk,
  input  logic                rstN,
  input  logic                pdN,
  input  logic                cpuStopN,
  input  logic                pciStopN,
  output logic [CPU_OUTS-1:0] cpuOut,
  output logic [PCI_OUTS-1:0] pciOut,
  output logic                pciFreeOut,
  output logic                refOut
);

  gateStrobes_t strobes;

  clockStopCtrl #(
    .SYNC_STAGES(SYNC_STAGES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) ctrl (
    .pciClk(pciClk), .refClk(refClk), .rstN(rstN), .pdN(pdN),
    .cpuStopN(cpuStopN), .pciStopN(pciStopN), .strobes(strobes)
  );

  clockStopPath #(
    .CPU_OUTS(CPU_OUTS), .PCI_OUTS(PCI_OUTS), .RESTART_CYCLES(RESTART_CYCLES)
  ) path (
    .cpuClk(cpuClk), .pciClk(pciClk), .refClk(refClk), .rstN(rstN),
    .strobes(strobes), .cpuOut(cpuOut), .pciOut(pciOut),
    .pciFreeOut(pciFreeOut), .refOut(refOut)
  );

endmodule

// File: rtl/clockStopChk.sv
module clockStopChk #(
  parameter int CPU_OUTS = 2,
  parameter int PCI_OUTS = 5
) (
  input logic                cpuClk,
  input logic                pciClk,
  input logic                refClk,
  input logic                rstN,
  input logic                pdN,
  input logic                cpuStopN,
  input logic                pciStopN,
  input logic [CPU_OUTS-1:0] cpuOut,
  input logic [PCI_OUTS-1:0] pciOut,
  input logic                pciFreeOut,
  input logic                refOut
);

  // R7 R9
  pd_quiet_chk: assert property (@(negedge pciClk) disable iff (!rstN)
    (!pdN && $past(!pdN) && $past(!pdN, 2)) |->
      (cpuOut == '0 && pciOut == '0 && !pciFreeOut));

  // R2
  cpu_stop_hold_chk: assert property (@(negedge pciClk) disable iff (!rstN)
    (!cpuStopN && $past(!cpuStopN) && $past(!cpuStopN, 2)) |-> (cpuOut == '0));

  // R3
  pci_stop_hold_chk: assert property (@(negedge pciClk) disable iff (!rstN)
    (!pciStopN && $past(!pciStopN) && $past(!pciStopN, 2)) |-> (pciOut == '0));

  // R11
  pci_low_phase_chk: assert property (@(posedge pciClk) disable iff (!rstN)
    (pciOut == '0 && !pciFreeOut));

  // R11
  cpu_low_phase_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    (cpuOut == '0));

  // R11
  ref_low_phase_chk: assert property (@(posedge refClk) disable iff (!rstN)
    !refOut);

  // R12
  free_covers_gated_chk: assert property (@(negedge pciClk) disable iff (!rstN)
    (pciOut != '0) |-> pciFreeOut);

endmodule

bind clockStopUnit clockStopChk #(.CPU_OUTS(CPU_OUTS), .PCI_OUTS(PCI_OUTS)) chkInst (
  .cpuClk(cpuClk), .pciClk(pciClk), .refClk(refClk), .rstN(rstN), .pdN(pdN),
  .cpuStopN(cpuStopN), .pciStopN(pciStopN), .cpuOut(cpuOut), .pciOut(pciOut),
  .pciFreeOut(pciFreeOut), .refOut(refOut)
);

// File: tb/clockStopUnit_test.sv
module clockStopUnit_test;

  localparam int PCI_P    = 30;
  localparam int CPU_P    = 10;
  localparam int REF_P    = 70;
  localparam int CPU_N    = 2;
  localparam int PCI_N    = 5;
  localparam int RESTART  = 3;
  localparam int SETTLE   = 16;
  localparam int DRIVE_OFS = 2;
  // time from a drive point to the second PCI rising edge
  localparam int SECOND_EDGE = PCI_P / 2 - DRIVE_OFS + PCI_P;
  localparam int WIN = 630;

  logic cpuClk = 1'b0, pciClk = 1'b0, refClk = 1'b0;
  logic rstN = 1'b1, pdN = 1'b1, cpuStopN = 1'b1, pciStopN = 1'b1;
  logic [CPU_N-1:0] cpuOut;
  logic [PCI_N-1:0] pciOut;
  logic pciFreeOut, refOut;

  clockStopUnit #(
    .CPU_OUTS(CPU_N), .PCI_OUTS(PCI_N), .SYNC_STAGES(2),
    .RESTART_CYCLES(RESTART), .SETTLE_CYCLES(SETTLE)
  ) uut (
    .cpuClk(cpuClk), .pciClk(pciClk), .refClk(refClk), .rstN(rstN), .pdN(pdN),
    .cpuStopN(cpuStopN), .pciStopN(pciStopN), .cpuOut(cpuOut), .pciOut(pciOut),
    .pciFreeOut(pciFreeOut), .refOut(refOut)
  );

  initial forever #(CPU_P / 2) cpuClk = ~cpuClk;
  initial forever #(PCI_P / 2) pciClk = ~pciClk;
  initial forever #(REF_P / 2) refClk = ~refClk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  bit monOn = 1'b0;

  function automatic void compare(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endfunction

  // Scoreboard queues
  typedef struct { string req; int value; } item_t;
  item_t expQ[$];
  int    actQ[$];

  task automatic pushExp(string req, int value);
    item_t it;
    it.req = req;
    it.value = value;
    expQ.push_back(it);
  endtask

  task automatic pushAct(int value);
    actQ.push_back(value);
  endtask

  initial forever begin
    item_t e;
    int a;
    wait (expQ.size() != 0 && actQ.size() != 0);
    e = expQ.pop_front();
    a = actQ.pop_front();
    compare(e.req, a, e.value);
  end

  // Pulse counters
  int cpuRise = 0, pciRise = 0, freeRise = 0, refRise = 0;
  always @(posedge cpuOut[1])  cpuRise++;
  always @(posedge pciOut[4])  pciRise++;
  always @(posedge pciFreeOut) freeRise++;
  always @(posedge refOut)     refRise++;

  // Pulse-shape monitors (R11)
  for (genvar i = 0; i < CPU_N; i++) begin : genCpuMon
    time tr = 0, tf = 0;
    always @(posedge cpuOut[i]) if (monOn) begin
      if (tf != 0) compare("R11 cpu low gap", int'(($time - tf) >= CPU_P / 2), 1);
      tr = $time;
    end
    always @(negedge cpuOut[i]) if (monOn && tr != 0) begin
      compare("R11 cpu high width", int'($time - tr), CPU_P / 2);
      tf = $time;
    end
  end

  for (genvar j = 0; j < PCI_N; j++) begin : genPciMon
    time tr = 0, tf = 0;
    always @(posedge pciOut[j]) if (monOn) begin
      if (tf != 0) compare("R11 pci low gap", int'(($time - tf) >= PCI_P / 2), 1);
      tr = $time;
    end
    always @(negedge pciOut[j]) if (monOn && tr != 0) begin
      compare("R11 pci high width", int'($time - tr), PCI_P / 2);
      tf = $time;
    end
  end

  time frTr = 0, frTf = 0, rfTr = 0, rfTf = 0;
  always @(posedge pciFreeOut) if (monOn) begin
    if (frTf != 0) compare("R11 free low gap", int'(($time - frTf) >= PCI_P / 2), 1);
    frTr = $time;
  end
  always @(negedge pciFreeOut) if (monOn && frTr != 0) begin
    compare("R11 free high width", int'($time - frTr), PCI_P / 2);
    frTf = $time;
  end
  always @(posedge refOut) if (monOn) begin
    if (rfTf != 0) compare("R11 ref low gap", int'(($time - rfTf) >= REF_P / 2), 1);
    rfTr = $time;
  end
  always @(negedge refOut) if (monOn && rfTr != 0) begin
    compare("R11 ref high width", int'($time - rfTr), REF_P / 2);
    rfTf = $time;
  end

  task automatic alignPci(int ofs);
    @(negedge pciClk);
    #(ofs);
  endtask

  // Counts pulses over a window; a negative expectation skips that output.
  task automatic windowCheck(string req, int eCpu, int ePci, int eFree, int eRef);
    int c0, p0, f0, r0;
    c0 = cpuRise; p0 = pciRise; f0 = freeRise; r0 = refRise;
    #(WIN);
    pushExp({req, " cpu pulses"}, eCpu);   pushAct(cpuRise - c0);
    pushExp({req, " pci pulses"}, ePci);   pushAct(pciRise - p0);
    pushExp({req, " free pulses"}, eFree); pushAct(freeRise - f0);
    if (eRef >= 0) begin
      pushExp({req, " ref pulses"}, eRef); pushAct(refRise - r0);
    end
  endtask

  task automatic settleCheck(string req);
    time t1, tRef, tFree;
    t1 = $time;
    fork
      begin @(posedge refOut);     tRef  = $time; end
      begin @(posedge pciFreeOut); tFree = $time; end
    join
    pushExp({req, " ref not early"}, 1);  pushAct(int'((tRef - t1) >= SETTLE * REF_P));
    pushExp({req, " ref in time"}, 1);    pushAct(int'((tRef - t1) <= (SETTLE + 6) * REF_P));
    pushExp({req, " free not early"}, 1); pushAct(int'((tFree - t1) >= SETTLE * REF_P));
  endtask

  initial begin
    time t0;
    #1 rstN = 1'b0;
    #200;
    // R1: reset state
    pushExp("R1 outputs in reset", 0);
    pushAct(int'({cpuOut, pciOut, pciFreeOut, refOut}));
    monOn = 1'b1;
    alignPci(7);
    rstN = 1'b1;
    settleCheck("R10 R1 after reset");
    #500;

    // R12 / R4 baseline
    alignPci(DRIVE_OFS);
    windowCheck("R12 running", WIN / CPU_P, WIN / PCI_P, WIN / PCI_P, WIN / REF_P);

    // R2 + R4: CPU stop
    alignPci(DRIVE_OFS);
    cpuStopN = 1'b0;
    windowCheck("R2 R4 cpu stop", 5, WIN / PCI_P, WIN / PCI_P, WIN / REF_P);
    windowCheck("R2 cpu held", 0, WIN / PCI_P, WIN / PCI_P, -1);

    // R6: CPU restart edge
    alignPci(DRIVE_OFS);
    cpuStopN = 1'b1;
    t0 = $time;
    @(posedge cpuOut[0]);
    pushExp("R6 cpu restart delay", SECOND_EDGE + (RESTART + 1) * CPU_P);
    pushAct(int'($time - t0));
    #300;

    // R3 + R4: PCI stop
    alignPci(DRIVE_OFS);
    pciStopN = 1'b0;
    windowCheck("R3 R4 pci stop", WIN / CPU_P, 2, WIN / PCI_P, WIN / REF_P);
    windowCheck("R3 pci held", WIN / CPU_P, 0, WIN / PCI_P, -1);

    // R5: PCI restart edge
    alignPci(DRIVE_OFS);
    pciStopN = 1'b1;
    t0 = $time;
    @(posedge pciOut[0]);
    pushExp("R5 pci restart delay", SECOND_EDGE + PCI_P);
    pushAct(int'($time - t0));
    #300;

    // R7 + R8: asynchronous power-down inside the PCI low phase
    alignPci(7);
    pdN = 1'b0;
    windowCheck("R7 pd entry", 0, 1, 1, -1);
    windowCheck("R7 R8 pd held", 0, 0, 0, 0);

    // R9: stop toggles while powered down
    alignPci(DRIVE_OFS);
    cpuStopN = 1'b0;
    pciStopN = 1'b0;
    #(3 * PCI_P);
    cpuStopN = 1'b1;
    pciStopN = 1'b1;
    windowCheck("R9 pd priority", 0, 0, 0, 0);

    // R10: power-up settle
    alignPci(7);
    pdN = 1'b1;
    settleCheck("R10 after power-down");
    #500;
    alignPci(DRIVE_OFS);
    windowCheck("R12 recovered", WIN / CPU_P, WIN / PCI_P, WIN / PCI_P, WIN / REF_P);

    wait (expQ.size() == 0 && actQ.size() == 0);
    #1;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(PCI_P * 20000);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule